// File: doc/BRIEF.md
# Raster Gating and Cursor Generator

This block makes programmable timing windows for a video raster. It takes a pixel clock, a horizontal pixel count and a vertical line count from outside. The start and end values of three windows also come from outside: a horizontal gate, a vertical gate and a vertical interrupt. From these it drives two output pins. When the composite sync and blank output is not selected, the two pins pass the externally produced horizontal and vertical drive. When that output is selected, a mode input picks what the pins carry. In gate mode they carry independent horizontal and vertical gating windows. In cursor mode they carry a cursor pulse, which is the horizontal window qualified by the vertical gate, and a vertical interrupt window.

Every window is half-open: it covers the positions from start up to, but not including, end. The horizontal window follows the pixel count directly. Each vertical window changes state only at one fixed point of the line, which is the same point where vertical blanking changes, so a vertical window holds steady for a whole line. All outputs are registered and follow their inputs after exactly one clock. A polarity input for each pin selects active-high or active-low drive in the two window modes.

Top module: `raster_gate_gen`

## Requirements
- R1: While `rst_n` is low, after the first clock edge, both `out_a` and `out_b` are 0, and both vertical window states are cleared.
- R2: With `comp_sel` = 0, `out_a` equals `hdrv_in` and `out_b` equals `vdrv_in` from one clock earlier, and polarity has no effect.
- R3: In gate mode (`comp_sel` = 1, `cursor_mode` = 0), the horizontal window is active in the cycle after `h_pos` lies in [`h_gate_start`, `h_gate_end`), and `out_a` carries that window.
- R4: The vertical gate state is set to (`v_pos` in [`v_gate_start`, `v_gate_end`)) on the cycle where `h_pos` equals LINE_EDGE (default 0), and is held at every other count. In gate mode, `out_b` carries this state one cycle later.
- R5: In cursor mode (`comp_sel` = 1, `cursor_mode` = 1), `out_a` carries the AND of the horizontal window and the vertical gate state. This gives one pulse of (`h_gate_end` − `h_gate_start`) clocks on each line inside the vertical gate.
- R6: In cursor mode, `out_b` carries the vertical interrupt state. That state is captured at LINE_EDGE from (`v_pos` in [`v_irq_start`, `v_irq_end`)) and is held for the rest of the line.
- R7: A window whose end value is less than or equal to its start value is never active.
- R8: In gate and cursor modes, `pol_a` and `pol_b` = 1 drive the active window as 1, and = 0 drive it as 0 with the idle level at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_pos | input | H_W | Horizontal pixel count |
| v_pos | input | V_W | Vertical line count |
| h_gate_start | input | H_W | Horizontal window start |
| h_gate_end | input | H_W | Horizontal window end (exclusive) |
| v_gate_start | input | V_W | Vertical gate start line |
| v_gate_end | input | V_W | Vertical gate end line (exclusive) |
| v_irq_start | input | V_W | Vertical interrupt start line |
| v_irq_end | input | V_W | Vertical interrupt end line (exclusive) |
| comp_sel | input | 1 | Composite sync/blank output selected |
| cursor_mode | input | 1 | 0 = gate mode, 1 = cursor mode |
| pol_a | input | 1 | Polarity of out_a in window modes (1 = active high) |
| pol_b | input | 1 | Polarity of out_b in window modes (1 = active high) |
| hdrv_in | input | 1 | External horizontal drive |
| vdrv_in | input | 1 | External vertical drive |
| out_a | output | 1 | Horizontal drive, horizontal gate or cursor |
| out_b | output | 1 | Vertical drive, vertical gate or vertical interrupt |

## Verification
The raster runs through complete frames with several window sets.

- A normal window checks the start-inclusive and end-exclusive edges.
- Windows where end equals start, and where end is below start, confirm that nothing is asserted.
- A vertical setting changed in the middle of a line shows that the vertical state waits for the next line edge rather than following the compare at once.
- Cursor frames that use different vertical gate and interrupt ranges distinguish a cursor that is correctly qualified by the gate from one qualified by the interrupt window.
- Random drive inputs with `comp_sel` low, and mode and polarity changes in the middle of a frame, confirm the one-cycle latency on every path.

// File: rtl/rg_pkg.sv
package rg_pkg;

    typedef enum logic [1:0] {
        RG_DRIVE  = 2'd0,
        RG_GATE   = 2'd1,
        RG_CURSOR = 2'd2
    } rg_mode_e;

    typedef struct packed {
        logic out_a;
        logic out_b;
    } rg_out_t;

    function automatic rg_mode_e rg_decode(input logic comp_sel, input logic cursor_mode);
        if (!comp_sel) return RG_DRIVE;
        if (cursor_mode) return RG_CURSOR;
        return RG_GATE;
    endfunction

endpackage

// File: rtl/rg_hwin.sv
module rg_hwin #(
    parameter int H_W = 12
) (
    input  logic [H_W-1:0] pos,
    input  logic [H_W-1:0] lo,
    input  logic [H_W-1:0] hi,
    output logic           in_win
);
    // Half-open compare: an end at or below the start gives an empty window.
    always_comb begin
        in_win = (pos >= lo) && (pos < hi);
    end
endmodule

// File: rtl/rg_vwin.sv
module rg_vwin #(
    parameter int H_W       = 12,
    parameter int V_W       = 11,
    parameter int LINE_EDGE = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [H_W-1:0] h_pos,
    input  logic [V_W-1:0] v_pos,
    input  logic [V_W-1:0] lo,
    input  logic [V_W-1:0] hi,
    output logic           win_d
);
    localparam logic [H_W-1:0] EDGE_CNT = H_W'(LINE_EDGE);

    logic win_q;
    logic at_edge;

    // Capture the line compare only at the line edge and hold it otherwise.
    always_comb begin
        at_edge = (h_pos == EDGE_CNT);
        win_d   = win_q;
        if (at_edge) begin
            win_d = (v_pos >= lo) && (v_pos < hi);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= 1'b0;
        else        win_q <= win_d;
    end
endmodule

// File: rtl/rg_outmux.sv
module rg_outmux
    import rg_pkg::*;
(
    input  rg_mode_e mode,
    input  logic     h_win,
    input  logic     vg_win,
    input  logic     vi_win,
    input  logic     pol_a,
    input  logic     pol_b,
    input  logic     hdrv_in,
    input  logic     vdrv_in,
    output rg_out_t  nxt
);
    logic raw_a;
    logic raw_b;

    always_comb begin
        raw_a = 1'b0;
        raw_b = 1'b0;
        nxt   = '0;
        unique case (mode)
            RG_GATE: begin
                raw_a = h_win;
                raw_b = vg_win;
            end
            RG_CURSOR: begin
                raw_a = h_win & vg_win;
                raw_b = vi_win;
            end
            default: begin
                raw_a = 1'b0;
                raw_b = 1'b0;
            end
        endcase
        if (mode == RG_DRIVE) begin
            nxt.out_a = hdrv_in;
            nxt.out_b = vdrv_in;
        end else begin
            nxt.out_a = pol_a ? raw_a : ~raw_a;
            nxt.out_b = pol_b ? raw_b : ~raw_b;
        end
    end
endmodule

// File: rtl/raster_gate_gen.sv
module raster_gate_gen
    import rg_pkg::*;
#(
    parameter int H_W       = 12,
    parameter int V_W       = 11,
    parameter int LINE_EDGE = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [H_W-1:0] h_pos,
    input  logic [V_W-1:0] v_pos,
    input  logic [H_W-1:0] h_gate_start,
    input  logic [H_W-1:0] h_gate_end,
    input  logic [V_W-1:0] v_gate_start,
    input  logic [V_W-1:0] v_gate_end,
    input  logic [V_W-1:0] v_irq_start,
    input  logic [V_W-1:0] v_irq_end,
    input  logic           comp_sel,
    input  logic           cursor_mode,
    input  logic           pol_a,
    input  logic           pol_b,
    input  logic           hdrv_in,
    input  logic           vdrv_in,
    output logic           out_a,
    output logic           out_b
);
    rg_out_t  st_d;
    rg_out_t  st_q;
    rg_mode_e mode;
    logic     h_win;
    logic     vg_d;
    logic     vi_d;

    rg_hwin #(.H_W(H_W)) u_hwin (
        .pos    (h_pos),
        .lo     (h_gate_start),
        .hi     (h_gate_end),
        .in_win (h_win)
    );

    rg_vwin #(.H_W(H_W), .V_W(V_W), .LINE_EDGE(LINE_EDGE)) u_vgate (
        .clk   (clk),
        .rst_n (rst_n),
        .h_pos (h_pos),
        .v_pos (v_pos),
        .lo    (v_gate_start),
        .hi    (v_gate_end),
        .win_d (vg_d)
    );

    rg_vwin #(.H_W(H_W), .V_W(V_W), .LINE_EDGE(LINE_EDGE)) u_virq (
        .clk   (clk),
        .rst_n (rst_n),
        .h_pos (h_pos),
        .v_pos (v_pos),
        .lo    (v_irq_start),
        .hi    (v_irq_end),
        .win_d (vi_d)
    );

    always_comb begin
        mode = rg_decode(comp_sel, cursor_mode);
    end

    rg_outmux u_mux (
        .mode    (mode),
        .h_win   (h_win),
        .vg_win  (vg_d),
        .vi_win  (vi_d),
        .pol_a   (pol_a),
        .pol_b   (pol_b),
        .hdrv_in (hdrv_in),
        .vdrv_in (vdrv_in),
        .nxt     (st_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_a = st_q.out_a;
    assign out_b = st_q.out_b;
endmodule

// File: rtl/raster_gate_chk.sv
module raster_gate_chk #(
    parameter int H_W       = 12,
    parameter int V_W       = 11,
    parameter int LINE_EDGE = 0
) (
    input logic           clk,
    input logic           rst_n,
    input logic [H_W-1:0] h_pos,
    input logic [V_W-1:0] v_pos,
    input logic [H_W-1:0] h_gate_start,
    input logic [H_W-1:0] h_gate_end,
    input logic [V_W-1:0] v_gate_start,
    input logic [V_W-1:0] v_gate_end,
    input logic [V_W-1:0] v_irq_start,
    input logic [V_W-1:0] v_irq_end,
    input logic           comp_sel,
    input logic           cursor_mode,
    input logic           pol_a,
    input logic           pol_b,
    input logic           hdrv_in,
    input logic           vdrv_in,
    input logic           out_a,
    input logic           out_b
);
    localparam logic [H_W-1:0] EDGE_CNT = H_W'(LINE_EDGE);

    logic clk_seen_q = 1'b0;
    logic live_q;

    always_ff @(posedge clk) clk_seen_q <= 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R1
    a_r1_reset_low: assert property (@(posedge clk)
        (clk_seen_q && !rst_n) |-> (!out_a && !out_b));

    // R2
    a_r2_drive_a: assert property (@(posedge clk) disable iff (!rst_n)
        !comp_sel |=> (out_a == $past(hdrv_in)));
    a_r2_drive_b: assert property (@(posedge clk) disable iff (!rst_n)
        !comp_sel |=> (out_b == $past(vdrv_in)));

    // R3, R8
    a_r3_hgate: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_sel && !cursor_mode) |=>
        (out_a == ($past(pol_a) ~^ $past((h_pos >= h_gate_start) && (h_pos < h_gate_end)))));

    // R4
    a_r4_vgate_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_sel && !cursor_mode && h_pos == EDGE_CNT) |=>
        (out_b == ($past(pol_b) ~^ $past((v_pos >= v_gate_start) && (v_pos < v_gate_end)))));
    a_r4_vgate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && comp_sel && !cursor_mode && h_pos != EDGE_CNT &&
         $past(comp_sel) && !$past(cursor_mode) && $stable(pol_b)) |=> $stable(out_b));

    // R5
    a_r5_cursor_in_h: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_sel && cursor_mode && !((h_pos >= h_gate_start) && (h_pos < h_gate_end))) |=>
        (out_a == !$past(pol_a)));

    // R6
    a_r6_irq_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_sel && cursor_mode && h_pos == EDGE_CNT) |=>
        (out_b == ($past(pol_b) ~^ $past((v_pos >= v_irq_start) && (v_pos < v_irq_end)))));

    // R7
    a_r7_hempty: assert property (@(posedge clk) disable iff (!rst_n)
        (comp_sel && h_gate_end <= h_gate_start) |=> (out_a == !$past(pol_a)));
endmodule

bind raster_gate_gen raster_gate_chk #(.H_W(H_W), .V_W(V_W), .LINE_EDGE(LINE_EDGE)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .h_pos        (h_pos),
    .v_pos        (v_pos),
    .h_gate_start (h_gate_start),
    .h_gate_end   (h_gate_end),
    .v_gate_start (v_gate_start),
    .v_gate_end   (v_gate_end),
    .v_irq_start  (v_irq_start),
    .v_irq_end    (v_irq_end),
    .comp_sel     (comp_sel),
    .cursor_mode  (cursor_mode),
    .pol_a        (pol_a),
    .pol_b        (pol_b),
    .hdrv_in      (hdrv_in),
    .vdrv_in      (vdrv_in),
    .out_a        (out_a),
    .out_b        (out_b)
);

// File: tb/raster_gate_gen_test.sv
module raster_gate_gen_test;
    localparam int H_W = 12;
    localparam int V_W = 11;
    localparam int HT  = 20;
    localparam int VT  = 12;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst_n;
    logic [H_W-1:0] h_pos, h_gate_start, h_gate_end;
    logic [V_W-1:0] v_pos, v_gate_start, v_gate_end, v_irq_start, v_irq_end;
    logic           comp_sel, cursor_mode, pol_a, pol_b, hdrv_in, vdrv_in;
    logic           out_a, out_b;

    raster_gate_gen uut (
        .clk(clk), .rst_n(rst_n), .h_pos(h_pos), .v_pos(v_pos),
        .h_gate_start(h_gate_start), .h_gate_end(h_gate_end),
        .v_gate_start(v_gate_start), .v_gate_end(v_gate_end),
        .v_irq_start(v_irq_start), .v_irq_end(v_irq_end),
        .comp_sel(comp_sel), .cursor_mode(cursor_mode),
        .pol_a(pol_a), .pol_b(pol_b), .hdrv_in(hdrv_in), .vdrv_in(vdrv_in),
        .out_a(out_a), .out_b(out_b)
    );

    int checks = 0;
    int fails  = 0;
    int hc, vc, hs, he, vs, ve, is_, ie;
    bit comp, cur, pa, pb, hd, vd;
    bit m_vg, m_vi, ea, eb, ev;
    string ta, tb;

    task automatic check(string tag, logic act, bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at h=%0d v=%0d: actual=%b expected=%b", tag, hc, vc, act, exp);
        end
    endtask

    task automatic apply();
        h_pos = H_W'(hc); v_pos = V_W'(vc);
        h_gate_start = H_W'(hs); h_gate_end = H_W'(he);
        v_gate_start = V_W'(vs); v_gate_end = V_W'(ve);
        v_irq_start = V_W'(is_); v_irq_end = V_W'(ie);
        comp_sel = comp; cursor_mode = cur; pol_a = pa; pol_b = pb;
        hdrv_in = hd; vdrv_in = vd;
    endtask

    // Reference model: vertical states update at line start, output one clock later.
    task automatic compute();
        bit hw;
        if (hc == 0) begin
            m_vg = (vc >= vs) && (vc < ve);
            m_vi = (vc >= is_) && (vc < ie);
        end
        hw = (hc >= hs) && (hc < he);
        if (!comp) begin
            ea = hd; eb = vd; ta = "R2"; tb = "R2";
        end else if (!cur) begin
            ea = pa ? hw : !hw;
            eb = pb ? m_vg : !m_vg;
            ta = (he <= hs) ? "R7/R3" : "R3";
            tb = (ve <= vs) ? "R7/R4" : "R4";
        end else begin
            ea = pa ? (hw && m_vg) : !(hw && m_vg);
            eb = pb ? m_vi : !m_vi;
            ta = "R5";
            tb = (ie <= is_) ? "R7/R6" : "R6";
        end
        if (comp && !pa) ta = {ta, "/R8"};
        if (comp && !pb) tb = {tb, "/R8"};
        ev = 1'b1;
    endtask

    task automatic step();
        @(negedge clk);
        if (ev) begin
            check(ta, out_a, ea);
            check(tb, out_b, eb);
        end
        hc++;
        if (hc == HT) begin
            hc = 0;
            vc = (vc + 1) % VT;
        end
        if (!comp) begin
            hd = 1'($urandom);
            vd = 1'($urandom);
        end
        apply();
        compute();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ev = 1'b0;
        hc = 0; vc = 0; hs = 3; he = 9; vs = 2; ve = 5; is_ = 8; ie = 10;
        comp = 1'b1; cur = 1'b0; pa = 1'b0; pb = 1'b0; hd = 1'b1; vd = 1'b1;
        m_vg = 1'b0; m_vi = 1'b0;
        apply();
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1", out_a, 1'b0);
            check("R1", out_b, 1'b0);
        end
        rst_n = 1'b1;
        comp = 1'b0;
        apply();
        compute();
        // R2: pass-through with random drives
        run(HT * VT);
        // R3/R4: gate mode, active high
        comp = 1'b1; cur = 1'b0; pa = 1'b1; pb = 1'b1;
        run(HT * VT);
        // R8: gate mode, active low, other window
        pa = 1'b0; pb = 1'b0; hs = 0; he = 19; vs = 0; ve = 11;
        run(HT * VT);
        // R7: empty windows (end equals start, end below start)
        pa = 1'b1; pb = 1'b1; hs = 7; he = 7; vs = 6; ve = 3;
        run(HT * VT / 2);
        hs = 12; he = 4; vs = 4; ve = 4;
        run(HT * VT / 2);
        // R4: vertical setting changed mid-line must wait for line edge
        hs = 2; he = 6; vs = 1; ve = 3;
        run(HT * 3 + 7);
        vs = 0; ve = 12;
        run(HT * 2);
        // R5/R6: cursor mode
        cur = 1'b1; vs = 4; ve = 7; is_ = 8; ie = 10; hs = 5; he = 11;
        run(HT * VT);
        // R8 in cursor mode, with R7 empty interrupt
        pa = 1'b0; pb = 1'b0; is_ = 9; ie = 2;
        run(HT * VT);
        // Mode switches mid-frame
        pb = 1'b1; is_ = 1; ie = 11;
        run(HT * 5 + 3);
        cur = 1'b0;
        run(HT * 2 + 9);
        comp = 1'b0;
        run(HT + 4);
        comp = 1'b1; cur = 1'b1;
        run(HT * VT);
        @(negedge clk);
        check(ta, out_a, ea);
        check(tb, out_b, eb);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule